// File: doc/BRIEF.md
# Charge-Injection Switch Sequencer

This block drives the four switches of a switched reference capacitor in a charge-balancing current digitizer. Each time the integrator output crosses the comparator threshold, the capacitor must be emptied, charged to the reference voltage and then tied to the integrator input. Tying it to the input removes one fixed packet of charge. The sequencer turns each crossing into exactly one such packet. It keeps the three switch groups apart with programmable dead time, so that no two groups conduct together.

The comparator level is synchronized inside the block, and only a rising edge starts a packet. A crossing that arrives during a packet is held as a single pending request. That request starts the next packet as soon as the current one ends. Any crossing beyond that is dropped and reported on a pulse output. A free-running window counter counts finished dump phases. At the end of each window it presents the total, which saturates at full scale, together with a one-cycle strobe. The input current is proportional to this count.

Every programmable length uses a minus-one encoding: a field value L gives L+1 cycles.

Top module: `cinj_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all switch controls, busy_o, drop_o, done_o and count_o are 0.
- R2: cmp_i passes through a two-flop synchronizer. A 0-to-1 change starts a packet, and the clear phase becomes visible after the third rising clock edge following the change. A level held high starts only one packet.
- R3: A packet runs clear for clr_len_i+1 cycles, a gap for dead_len_i+1 cycles, charge for chg_len_i+1 cycles, a gap, dump for dmp_len_i+1 cycles, and a final gap. Every gap lasts dead_len_i+1 cycles. In a gap all switch controls are 0.
- R4: Both clear switches (sw_clr_a_o, sw_clr_b_o) are equal in every cycle. At most one of the clear, charge and dump groups is high in any cycle.
- R5: busy_o is 1 from the first clear cycle through the last cycle of the final gap, and 0 when no packet is in progress.
- R6: A rising edge seen during a packet is stored as one pending request. Its clear phase begins in the cycle right after the final gap, with no idle cycle between.
- R7: A rising edge seen while a request is already pending causes no extra packet. It makes drop_o high for one cycle.
- R8: done_o is high for one cycle once every win_len_i+1 cycles.
- R9: When done_o rises, count_o takes the number of dump phases that ended during that window. count_o does not change in any other cycle.
- R10: The window count saturates at 2**CNT_W-1 (255 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cmp_i | input | 1 | Asynchronous threshold comparator level |
| clr_len_i | input | LEN_W | Clear phase length minus one |
| chg_len_i | input | LEN_W | Charge phase length minus one |
| dmp_len_i | input | LEN_W | Dump phase length minus one |
| dead_len_i | input | LEN_W | Dead time between phases minus one |
| win_len_i | input | WIN_W | Counting window length minus one |
| sw_clr_a_o | output | 1 | First residual-charge clear switch |
| sw_clr_b_o | output | 1 | Second residual-charge clear switch |
| sw_chg_o | output | 1 | Reference charge switch |
| sw_dmp_o | output | 1 | Dump-to-integrator switch |
| busy_o | output | 1 | Packet in progress |
| drop_o | output | 1 | One-cycle pulse when a request is discarded |
| count_o | output | CNT_W | Packets completed in the last window |
| done_o | output | 1 | One-cycle end-of-window strobe |

## Verification
If the phase state or its timer holds a wrong value, the per-cycle switch pattern leaves the expected run lengths. This shows up at once, in the phase where the error occurs, and the bench compares that pattern on every cycle across a sweep of all small phase and dead-time settings. A lost or duplicated pending flag shows up at the end of the packet: either the back-to-back clear phase is missing, an extra packet appears, or the drop pulse count differs. A bad window counter or accumulator shows up at the next strobe, through a wrong period, a wrong total or a wrap past full scale.

// File: rtl/cinj_pkg.sv
package cinj_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLR,
    PH_GAP1,
    PH_CHG,
    PH_GAP2,
    PH_DMP,
    PH_GAP3
  } phase_e;
endpackage

// File: rtl/cinj_edge.sv
module cinj_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], lvl_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/cinj_phase.sv
module cinj_phase
  import cinj_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [LEN_W-1:0] clr_len_i,
  input  logic [LEN_W-1:0] chg_len_i,
  input  logic [LEN_W-1:0] dmp_len_i,
  input  logic [LEN_W-1:0] dead_len_i,
  output logic             sw_clr_o,
  output logic             sw_chg_o,
  output logic             sw_dmp_o,
  output logic             busy_o,
  output logic             dump_done_o,
  output logic             drop_o
);
  phase_e           st_q, st_d;
  logic [LEN_W-1:0] tmr_q, tmr_d;
  logic [LEN_W-1:0] cur_len;
  logic             last;
  logic             pend_q, pend_d;
  logic             drop_q, drop_d;
  logic             consume;

  always_comb begin
    unique case (st_q)
      PH_CLR:  cur_len = clr_len_i;
      PH_CHG:  cur_len = chg_len_i;
      PH_DMP:  cur_len = dmp_len_i;
      default: cur_len = dead_len_i;
    endcase
  end

  assign last    = (tmr_q == cur_len);
  assign busy_o  = (st_q != PH_IDLE);
  assign consume = pend_q & ((st_q == PH_IDLE) | ((st_q == PH_GAP3) & last));

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q + 1'b1;
    if (st_q == PH_IDLE) begin
      tmr_d = '0;
      if (req_i || pend_q) st_d = PH_CLR;
    end else if (last) begin
      tmr_d = '0;
      unique case (st_q)
        PH_CLR:  st_d = PH_GAP1;
        PH_GAP1: st_d = PH_CHG;
        PH_CHG:  st_d = PH_GAP2;
        PH_GAP2: st_d = PH_DMP;
        PH_DMP:  st_d = PH_GAP3;
        default: st_d = pend_q ? PH_CLR : PH_IDLE;
      endcase
    end
  end

  always_comb begin
    pend_d = (pend_q & ~consume) | (req_i & busy_o);
    drop_d = req_i & busy_o & pend_q & ~consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      tmr_q  <= '0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      drop_q <= drop_d;
    end
  end

  assign sw_clr_o    = (st_q == PH_CLR);
  assign sw_chg_o    = (st_q == PH_CHG);
  assign sw_dmp_o    = (st_q == PH_DMP);
  assign dump_done_o = (st_q == PH_DMP) & last;
  assign drop_o      = drop_q;

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_clr_o, sw_chg_o, sw_dmp_o}) <= 1); // R4
  AST_CHG_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_chg_o) |-> $past(!sw_clr_o && !sw_dmp_o && busy_o)); // R3
  AST_DMP_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_dmp_o) |-> $past(!sw_clr_o && !sw_chg_o && busy_o)); // R3
  AST_PEND_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy_o) |=> sw_clr_o); // R6
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(busy_o)); // R7
endmodule

// File: rtl/cinj_window.sv
module cinj_window #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] acc_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             term;

  assign term    = (wcnt_q >= win_len_i);
  assign acc_inc = (inc_i && acc_q != CNT_MAX) ? acc_q + 1'b1 : acc_q;

  always_comb begin
    wcnt_d = term ? '0 : wcnt_q + 1'b1;
    acc_d  = term ? '0 : acc_inc;
    cnt_d  = term ? acc_inc : cnt_q;
    done_d = term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign count_o = cnt_q;
  assign done_o  = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && win_len_i != '0) |=> !done_o); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(count_o)); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(term) |-> (acc_q >= $past(acc_q))); // R10
endmodule

// File: rtl/cinj_seq.sv
module cinj_seq #(
  parameter int LEN_W   = 4,
  parameter int WIN_W   = 16,
  parameter int CNT_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic [LEN_W-1:0] clr_len_i,
  input  logic [LEN_W-1:0] chg_len_i,
  input  logic [LEN_W-1:0] dmp_len_i,
  input  logic [LEN_W-1:0] dead_len_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             sw_clr_a_o,
  output logic             sw_clr_b_o,
  output logic             sw_chg_o,
  output logic             sw_dmp_o,
  output logic             busy_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic req;
  logic sw_clr;
  logic dump_done;

  cinj_edge #(.STAGES(SYNC_ST)) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (cmp_i),
    .rise_o (req)
  );

  cinj_phase #(.LEN_W(LEN_W)) phase_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .clr_len_i   (clr_len_i),
    .chg_len_i   (chg_len_i),
    .dmp_len_i   (dmp_len_i),
    .dead_len_i  (dead_len_i),
    .sw_clr_o    (sw_clr),
    .sw_chg_o    (sw_chg_o),
    .sw_dmp_o    (sw_dmp_o),
    .busy_o      (busy_o),
    .dump_done_o (dump_done),
    .drop_o      (drop_o)
  );

  cinj_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) window_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_len_i (win_len_i),
    .inc_i     (dump_done),
    .count_o   (count_o),
    .done_o    (done_o)
  );

  assign sw_clr_a_o = sw_clr;
  assign sw_clr_b_o = sw_clr;

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_a_o || sw_chg_o || sw_dmp_o) |-> busy_o); // R5
  AST_CLR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_a_o == sw_clr_b_o); // R4
endmodule

// File: tb/cinj_seq_tb.sv
module cinj_seq_tb_top;
  localparam int LEN_W = 4;
  localparam int WIN_W = 16;
  localparam int CNT_W = 8;

  localparam logic [4:0] C_IDLE = 5'b00000;
  localparam logic [4:0] C_CLR  = 5'b10011;
  localparam logic [4:0] C_GAP  = 5'b10000;
  localparam logic [4:0] C_CHG  = 5'b10100;
  localparam logic [4:0] C_DMP  = 5'b11000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmp_i;
  logic [LEN_W-1:0] clr_len, chg_len, dmp_len, dead_len;
  logic [WIN_W-1:0] win_len;
  logic             sw_clr_a, sw_clr_b, sw_chg, sw_dmp, busy, drop, done;
  logic [CNT_W-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int drop_seen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cinj_seq #(.LEN_W(LEN_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_i      (cmp_i),
    .clr_len_i  (clr_len),
    .chg_len_i  (chg_len),
    .dmp_len_i  (dmp_len),
    .dead_len_i (dead_len),
    .win_len_i  (win_len),
    .sw_clr_a_o (sw_clr_a),
    .sw_clr_b_o (sw_clr_b),
    .sw_chg_o   (sw_chg),
    .sw_dmp_o   (sw_dmp),
    .busy_o     (busy),
    .drop_o     (drop),
    .count_o    (count),
    .done_o     (done)
  );

  always @(negedge clk) if (drop) drop_seen++;

  function automatic logic [4:0] obs();
    return {busy, sw_dmp, sw_chg, sw_clr_b, sw_clr_a};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_run(input logic [4:0] code, input int n, input string req);
    int bad_at = -1;
    logic [4:0] got = code;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (obs() !== code && bad_at < 0) begin
        bad_at = i;
        got = obs();
      end
    end
    check(bad_at < 0, req, int'(got), int'(code));
  endtask

  task automatic expect_packet(input int c, input int g, input int m, input int d);
    expect_run(C_CLR, c + 1, "R3 clear");
    expect_run(C_GAP, d + 1, "R3 gap1");
    expect_run(C_CHG, g + 1, "R3 charge");
    expect_run(C_GAP, d + 1, "R3 gap2");
    expect_run(C_DMP, m + 1, "R3 dump");
    expect_run(C_GAP, d + 1, "R5 final gap busy");
  endtask

  task automatic wait_done();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 10000);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmp_i = 1'b0;
    clr_len = '0; chg_len = '0; dmp_len = '0; dead_len = '0;
    win_len = 16'd199;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({obs(), drop, done} == 7'd0 && count == '0, "R1 reset outputs", int'({obs(), drop, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({obs(), drop, done} == 7'd0 && count == '0, "R1 after release", int'({obs(), drop, done}), 0);

    // R2 R3 R4 R5: sweep of all small phase and dead lengths, level held through the packet
    for (int c = 0; c < 3; c++)
      for (int g = 0; g < 3; g++)
        for (int m = 0; m < 3; m++)
          for (int d = 0; d < 3; d++) begin
            clr_len = LEN_W'(c); chg_len = LEN_W'(g);
            dmp_len = LEN_W'(m); dead_len = LEN_W'(d);
            cmp_i = 1'b1;
            expect_run(C_IDLE, 2, "R2 sync latency");
            expect_packet(c, g, m, d);
            expect_run(C_IDLE, 2, "R2 held level gives one packet");
            cmp_i = 1'b0;
            expect_run(C_IDLE, 2, "R5 idle");
          end

    // R6 R7: requests during a packet
    clr_len = 4'd3; chg_len = 4'd3; dmp_len = 4'd3; dead_len = 4'd1;
    drop_seen = 0;
    fork
      begin
        for (int i = 0; i < 16; i++) begin
          cmp_i = ((i / 2) % 2 == 0) && i < 14;
          @(negedge clk);
        end
        cmp_i = 1'b0;
      end
      begin
        expect_run(C_IDLE, 2, "R2 first request");
        expect_packet(3, 3, 3, 1);
        expect_packet(3, 3, 3, 1); // R6 pending served back to back
        expect_run(C_IDLE, 6, "R7 no extra packet");
      end
    join
    check(drop_seen == 2, "R7 drop pulses", drop_seen, 2);

    // R8 R9: window of 200 cycles with five packets
    clr_len = '0; chg_len = '0; dmp_len = '0; dead_len = '0;
    wait_done();
    begin
      int cyc = 0;
      do begin
        cmp_i = (cyc % 12 < 2) && cyc < 60;
        @(negedge clk);
        cyc++;
      end while (!done && cyc < 10000);
      cmp_i = 1'b0;
      check(cyc == 200, "R8 window period", cyc, 200);
      check(count == 8'd5, "R9 packet count", int'(count), 5);
      @(negedge clk);
      check(!done, "R8 strobe one cycle", int'(done), 0);
      check(count == 8'd5, "R9 count held", int'(count), 5);
    end

    // R10: saturation over a long window
    win_len = 16'd2999;
    wait_done();
    begin
      int cyc = 0;
      do begin
        cmp_i = (cyc % 6 < 3);
        @(negedge clk);
        cyc++;
      end while (!done && cyc < 10000);
      cmp_i = 1'b0;
      check(cyc == 3000, "R8 long window period", cyc, 3000);
      check(count == 8'd255, "R10 saturated count", int'(count), 255);
    end

    // R9: an empty window reports zero
    wait_done();
    wait_done();
    check(count == 8'd0, "R9 empty window", int'(count), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule